// File: doc/BRIEF.md
# Dual-wiper serial command slave with chain pass-through

This block is the digital front end of a two-channel digitally controlled resistor. A host sends 16-bit command words over a four-wire serial bus: a serial clock, a chip select that is active low, a data input and a data output. Each word is shifted in most significant bit first. Its top nibble is the operation code, the next nibble is a register address and the low byte is the data. Nothing is executed while chip select is low. The word is decoded and carried out only after chip select goes high again. The slave owns two 8-bit wiper registers and a sixteen-entry, 8-bit register file that stands in for nonvolatile storage.

The data output has two roles, chosen by the last executed operation. After a wiper-read or storage-read operation, the requested byte is reloaded into the shift register. It then leaves, most significant bit first, on the first eight clocks of the next frame. After any other operation, the output simply carries the bits that fall out of the shift register. Two slaves can therefore be chained output-to-input and loaded with one 32-bit frame. The data output is released to high impedance whenever chip select is high.

All bus pins are resynchronised into the system clock domain. Both bus modes that sample on the rising serial clock edge are handled: idle-low clock with first-edge capture, and idle-high clock with second-edge capture. An active-low write-protect pin blocks every register write but leaves reads and pass-through intact.

Top module: `spi_wiper_slave`

## Requirements
- R1: After reset both wipers hold 0x80, the low-power flag is 0 and the data output is high impedance.
- R2: A word is taken as 16 bits, first bit received = bit 15; bits 15..12 are the operation, 11..8 the address, 7..0 the data; registers change only after chip select rises, never while it is still low.
- R3: Operation 0xB writes the data byte to the wiper picked by address bit 0 (0 = wipers_o[7:0], 1 = wipers_o[15:8]); the other wiper keeps its value.
- R4: Operation 0x3 writes the data byte into storage entry address[3:0].
- R5: After operation 0xA, the wiper picked by address bit 0 appears on the data output during the first 8 rising clock edges of the next frame, most significant bit first.
- R6: After operation 0x9, storage entry address[3:0] appears on the data output in the same way as in R5.
- R7: After any operation other than 0x9 and 0xA, the data output replays the shift-register contents. In a 32-bit frame, the data output first carries the previous 16-bit word, then the first 16 bits sent in the frame. Only the last 16 bits sent are executed.
- R8: A frame whose bit count is zero or not a multiple of 16 is discarded: no register and no low-power change.
- R9: Executing operation 0x0 sets low_power_o; executing any other valid word clears it.
- R10: Operations other than 0x3 and 0xB leave wipers and storage unchanged.
- R11: While wp_n_i is 0, operations 0xB and 0x3 change nothing, while reads and pass-through still work.
- R12: The data output is high impedance while chip select is high and driven while it is low.
- R13: Idle-low clock frames and idle-high clock frames give identical results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, several times faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_clk_i | input | 1 | Serial clock from the host |
| spi_csn_i | input | 1 | Chip select, active low |
| spi_sdi_i | input | 1 | Serial data in |
| wp_n_i | input | 1 | Write protect, active low |
| spi_sdo_o | output | 1 | Serial data out, high impedance when deselected |
| wipers_o | output | 16 | Wiper values, wiper 0 in the low byte |
| low_power_o | output | 1 | Low-power indication |

## Verification
A rising chip select reaches the registers after two synchroniser flops, one edge register, two decode stages and the write. Wiper, storage and low-power results therefore appear about five system clocks after the pin. The bench waits fifty clocks after every release before it compares. A falling serial clock moves the data output about four system clocks later. The bench reads the data output at the next rising serial clock, which comes ten system clocks after the falling edge, so every captured bit is settled. The hold-low check reads the wipers long after the last bit but before chip select rises. This shows that execution waits for the release.

// File: rtl/spi_wiper_pkg.sv
package spi_wiper_pkg;
  localparam int OP_W    = 4;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 8;
  localparam int FRAME_W = OP_W + ADDR_W + DATA_W;

  localparam logic [OP_W-1:0] OP_NOP      = 4'h0;
  localparam logic [OP_W-1:0] OP_MEM_WR   = 4'h3;
  localparam logic [OP_W-1:0] OP_MEM_RD   = 4'h9;
  localparam logic [OP_W-1:0] OP_WIPER_RD = 4'hA;
  localparam logic [OP_W-1:0] OP_WIPER_WR = 4'hB;

  typedef struct packed {
    logic [OP_W-1:0]   op;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } frame_t;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int N = 4,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] ff;
    always_ff @(posedge clk) begin
      if (rst) ff <= {STAGES{RST_VAL[i]}};
      else     ff <= {ff[STAGES-2:0], async_i[i]};
    end
    assign sync_o[i] = ff[STAGES-1];
  end
endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter #(
  parameter int W = 16,
  localparam int CNT_W = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cs_low_i,
  input  logic         cs_fall_i,
  input  logic         sclk_rise_i,
  input  logic         sclk_fall_i,
  input  logic         sdi_i,
  input  logic         load_en_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] word_o,
  output logic         frame_ok_o,
  output logic         sdo_o
);
  logic [W-1:0]     shreg;
  logic [CNT_W-1:0] cnt;
  logic             full_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg     <= '0;
      cnt       <= '0;
      full_seen <= 1'b0;
      sdo_o     <= 1'b0;
    end else begin
      if (cs_fall_i) begin
        cnt       <= '0;
        full_seen <= 1'b0;
        sdo_o     <= shreg[W-1];
      end else if (cs_low_i && sclk_rise_i) begin
        shreg <= {shreg[W-2:0], sdi_i};
        cnt   <= cnt + 1'b1;
        if (cnt == CNT_W'(W-1)) full_seen <= 1'b1;
      end else if (cs_low_i && sclk_fall_i) begin
        sdo_o <= shreg[W-1];
      end
      if (load_en_i && !cs_low_i) shreg <= load_val_i;
    end
  end

  assign word_o     = shreg;
  assign frame_ok_o = full_seen && (cnt == '0);

  // R2
  shreg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs_low_i && !load_en_i) |=> $stable(shreg));
endmodule

// File: rtl/wiper_mem_bank.sv
module wiper_mem_bank #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter int NUM_WIPERS = 2,
  parameter logic [DATA_W-1:0] WIPER_RESET = 8'h80,
  localparam int WSEL_W = (NUM_WIPERS > 1) ? $clog2(NUM_WIPERS) : 1,
  localparam int DEPTH = 2 ** ADDR_W
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wiper_we_i,
  input  logic [WSEL_W-1:0]            wiper_sel_i,
  input  logic                         mem_we_i,
  input  logic [ADDR_W-1:0]            wr_addr_i,
  input  logic [DATA_W-1:0]            wdata_i,
  input  logic [ADDR_W-1:0]            rd_addr_i,
  output logic [DATA_W-1:0]            mem_rdata_o,
  output logic [NUM_WIPERS*DATA_W-1:0] wipers_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (mem_we_i) mem[wr_addr_i] <= wdata_i;
    mem_rdata_o <= mem[rd_addr_i];
  end

  for (genvar i = 0; i < NUM_WIPERS; i++) begin : g_wiper
    always_ff @(posedge clk) begin
      if (rst) wipers_o[i*DATA_W +: DATA_W] <= WIPER_RESET;
      else if (wiper_we_i && wiper_sel_i == WSEL_W'(i))
        wipers_o[i*DATA_W +: DATA_W] <= wdata_i;
    end
  end

  // R10
  wiper_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wiper_we_i |=> $stable(wipers_o));
endmodule

// File: rtl/spi_wiper_slave.sv
module spi_wiper_slave
  import spi_wiper_pkg::*;
#(
  parameter int NUM_WIPERS = 2,
  parameter int SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] WIPER_RESET = 8'h80,
  localparam int WSEL_W = (NUM_WIPERS > 1) ? $clog2(NUM_WIPERS) : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         spi_clk_i,
  input  logic                         spi_csn_i,
  input  logic                         spi_sdi_i,
  input  logic                         wp_n_i,
  output logic                         spi_sdo_o,
  output logic [NUM_WIPERS*DATA_W-1:0] wipers_o,
  output logic                         low_power_o
);
  logic [3:0] pins_sync;
  logic sclk_s, csn_s, sdi_s, wp_n_s;
  logic sclk_d, csn_d;
  logic sclk_rise, sclk_fall, cs_rise, cs_fall, cs_low;

  spi_pin_sync #(.N(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1010)) u_sync (
    .clk(clk), .rst(rst),
    .async_i({wp_n_i, spi_sdi_i, spi_csn_i, spi_clk_i}),
    .sync_o(pins_sync)
  );
  assign {wp_n_s, sdi_s, csn_s, sclk_s} = pins_sync;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      csn_d  <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      csn_d  <= csn_s;
    end
  end
  assign sclk_rise = sclk_s & ~sclk_d;
  assign sclk_fall = ~sclk_s & sclk_d;
  assign cs_rise   = csn_s & ~csn_d;
  assign cs_fall   = ~csn_s & csn_d;
  assign cs_low    = ~csn_s;

  logic [FRAME_W-1:0] rx_word;
  logic               frame_ok;
  logic               sdo_bit;
  logic               load_en;
  logic [FRAME_W-1:0] load_val;

  spi_frame_shifter #(.W(FRAME_W)) u_shift (
    .clk(clk), .rst(rst),
    .cs_low_i(cs_low), .cs_fall_i(cs_fall),
    .sclk_rise_i(sclk_rise), .sclk_fall_i(sclk_fall),
    .sdi_i(sdi_s),
    .load_en_i(load_en), .load_val_i(load_val),
    .word_o(rx_word), .frame_ok_o(frame_ok), .sdo_o(sdo_bit)
  );

  // two-stage execute: stage 1 latches the word, stage 2 has storage data
  logic   p1_vld, p2_vld;
  frame_t p1_word, p2_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      p1_vld  <= 1'b0;
      p2_vld  <= 1'b0;
      p1_word <= '0;
      p2_word <= '0;
    end else begin
      p1_vld  <= cs_rise && frame_ok;
      if (cs_rise) p1_word <= frame_t'(rx_word);
      p2_vld  <= p1_vld;
      p2_word <= p1_word;
    end
  end

  logic              wiper_we, mem_we;
  logic [DATA_W-1:0] mem_rdata, wiper_rd, rd_byte;
  logic              is_read;

  assign wiper_we = p2_vld && (p2_word.op == OP_WIPER_WR) && wp_n_s;
  assign mem_we   = p2_vld && (p2_word.op == OP_MEM_WR) && wp_n_s;
  assign is_read  = (p2_word.op == OP_MEM_RD) || (p2_word.op == OP_WIPER_RD);
  assign wiper_rd = wipers_o[p2_word.addr[WSEL_W-1:0]*DATA_W +: DATA_W];
  assign rd_byte  = (p2_word.op == OP_MEM_RD) ? mem_rdata : wiper_rd;
  assign load_en  = p2_vld && is_read;
  assign load_val = {rd_byte, {(FRAME_W-DATA_W){1'b0}}};

  wiper_mem_bank #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_WIPERS(NUM_WIPERS),
    .WIPER_RESET(WIPER_RESET)
  ) u_bank (
    .clk(clk), .rst(rst),
    .wiper_we_i(wiper_we), .wiper_sel_i(p2_word.addr[WSEL_W-1:0]),
    .mem_we_i(mem_we), .wr_addr_i(p2_word.addr), .wdata_i(p2_word.data),
    .rd_addr_i(p1_word.addr), .mem_rdata_o(mem_rdata),
    .wipers_o(wipers_o)
  );

  always_ff @(posedge clk) begin
    if (rst)         low_power_o <= 1'b0;
    else if (p2_vld) low_power_o <= (p2_word.op == OP_NOP);
  end

  logic sdo_oe;
  always_ff @(posedge clk) begin
    if (rst) sdo_oe <= 1'b0;
    else     sdo_oe <= cs_low;
  end
  assign spi_sdo_o = sdo_oe ? sdo_bit : 1'bz;

  // R2
  exec_cs_high_chk: assert property (@(posedge clk) disable iff (rst)
    p2_vld |-> csn_s);

  // R11
  wp_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    !wp_n_s |=> $stable(wipers_o));

  // R9
  lp_set_by_exec_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(low_power_o) |-> $past(p2_vld));
endmodule

// File: tb/test_spi_wiper_slave.sv
`timescale 1ns/1ps
module test_spi_wiper_slave;
  localparam int H = 40;
  localparam int SETTLE = 200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, csn = 1'b1, sdi = 1'b0, wp_n = 1'b1;
  wire  sdo;
  logic [15:0] wipers;
  logic lp;
  int vec = 0, bad = 0;
  bit done = 0;

  logic [7:0] exp_w [2];
  logic [7:0] exp_mem [16];
  logic [31:0] rx;

  always #2 clk = ~clk;

  spi_wiper_slave i_spi_wiper_slave (
    .clk(clk), .rst(rst),
    .spi_clk_i(sclk), .spi_csn_i(csn), .spi_sdi_i(sdi), .wp_n_i(wp_n),
    .spi_sdo_o(sdo), .wipers_o(wipers), .low_power_o(lp)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic release_cs();
    #H; csn = 1'b1; #SETTLE;
  endtask

  task automatic xfer(input logic [31:0] tx, input int nbits, input bit m3,
                      input bit hold, output logic [31:0] r);
    r = '0;
    sclk = m3;
    #H; csn = 1'b0;
    #H;
    for (int i = 0; i < nbits; i++) begin
      if (m3) begin
        sclk = 1'b0; sdi = tx[nbits-1-i]; #H;
        sclk = 1'b1; r = {r[30:0], sdo}; #H;
      end else begin
        sdi = tx[nbits-1-i]; #H;
        sclk = 1'b1; r = {r[30:0], sdo}; #H;
        sclk = 1'b0;
      end
    end
    if (!hold) release_cs();
  endtask

  task automatic send16(input logic [15:0] w, input bit m3);
    logic [31:0] d;
    xfer({16'h0, w}, 16, m3, 1'b0, d);
  endtask

  task automatic read_back(input logic [15:0] cmd, input bit m3, input logic [7:0] exp, input string req);
    logic [31:0] d;
    send16(cmd, m3);
    xfer(32'h0, 16, m3, 1'b0, d);
    chk(req, {24'h0, d[15:8]}, {24'h0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      vec++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    exp_w[0] = 8'h80; exp_w[1] = 8'h80;
    repeat (10) @(posedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    #100;

    // R1 reset state, R12 output released
    chk("R1 wipers", {16'h0, wipers}, 32'h8080);
    chk("R1 low_power", {31'h0, lp}, 32'h0);
    chk("R12 sdo idle", {31'h0, sdo === 1'bz}, 32'h1);

    // R2: word held with chip select low is not yet executed
    xfer({16'h0, 16'hB03C}, 16, 1'b0, 1'b1, rx);
    #SETTLE;
    chk("R2 before release", {16'h0, wipers}, 32'h8080);
    chk("R12 sdo driven", {31'h0, sdo === 1'bz}, 32'h0);
    release_cs();
    exp_w[0] = 8'h3C;
    chk("R2 after release", {16'h0, wipers}, {16'h0, exp_w[1], exp_w[0]});
    chk("R12 sdo released", {31'h0, sdo === 1'bz}, 32'h1);

    // R3 R5 R9 R13: wiper write / readback sweep in both bus modes
    for (int k = 0; k < 32; k++) begin
      logic [7:0] d8;
      bit sel, m3;
      d8 = 8'((k * 37 + 5) & 255);
      sel = k[0];
      m3 = k[1];
      send16({4'hB, 3'b0, sel, d8}, m3);
      exp_w[sel] = d8;
      chk(m3 ? "R3 R13 write" : "R3 write", {16'h0, wipers}, {16'h0, exp_w[1], exp_w[0]});
      chk("R9 cleared", {31'h0, lp}, 32'h0);
      read_back({4'hA, 3'b0, sel, 8'h00}, m3, d8, m3 ? "R5 R13 wiper read" : "R5 wiper read");
      chk("R9 set by nop", {31'h0, lp}, 32'h1);
    end

    // R4 R6: storage fill and readback
    for (int a = 0; a < 16; a++) begin
      exp_mem[a] = 8'((a * 13 + 7) & 255);
      send16({4'h3, 4'(a), exp_mem[a]}, a[0]);
    end
    for (int a = 0; a < 16; a++)
      read_back({4'h9, 4'(a), 8'h00}, a[1], exp_mem[a], "R4 R6 storage read");

    // R10: other code changes nothing
    send16(16'h5211, 1'b0);
    chk("R10 wipers", {16'h0, wipers}, {16'h0, exp_w[1], exp_w[0]});
    chk("R9 cleared by other", {31'h0, lp}, 32'h0);
    read_back(16'h9200, 1'b0, exp_mem[2], "R10 storage");

    // R7: 32-bit chained frame in both modes
    for (int m = 0; m < 2; m++) begin
      logic [15:0] prev, w1, w2;
      prev = (m == 0) ? 16'h5C12 : 16'h7E81;
      w1 = (m == 0) ? 16'hC3A5 : 16'h4B6D;
      w2 = (m == 0) ? 16'hB15A : 16'hB0A7;
      send16(prev, m[0]);
      xfer({w1, w2}, 32, m[0], 1'b0, rx);
      exp_w[w2[8]] = w2[7:0];
      chk("R7 previous word out", {16'h0, rx[31:16]}, {16'h0, prev});
      chk("R7 first half passed", {16'h0, rx[15:0]}, {16'h0, w1});
      chk("R7 last half executed", {16'h0, wipers}, {16'h0, exp_w[1], exp_w[0]});
    end

    // R8: bad bit counts are discarded
    send16(16'h0000, 1'b0);
    xfer({20'h0, 12'hB0F}, 12, 1'b0, 1'b0, rx);
    chk("R8 12 bits", {16'h0, wipers}, {16'h0, exp_w[1], exp_w[0]});
    xfer({12'h0, 20'hFB077}, 20, 1'b1, 1'b0, rx);
    chk("R8 20 bits", {16'h0, wipers}, {16'h0, exp_w[1], exp_w[0]});
    xfer(32'h0, 0, 1'b0, 1'b0, rx);
    chk("R8 zero bits", {16'h0, wipers}, {16'h0, exp_w[1], exp_w[0]});
    chk("R8 low_power kept", {31'h0, lp}, 32'h1);

    // R11: write protect
    wp_n = 1'b0;
    #SETTLE;
    send16(16'hB099, 1'b0);
    chk("R11 wiper blocked", {16'h0, wipers}, {16'h0, exp_w[1], exp_w[0]});
    send16(16'h34EE, 1'b1);
    read_back(16'h9400, 1'b0, exp_mem[4], "R11 storage blocked");
    read_back(16'hA100, 1'b1, exp_w[1], "R11 read allowed");
    wp_n = 1'b1;
    #SETTLE;
    send16(16'hB042, 1'b0);
    exp_w[0] = 8'h42;
    chk("R11 write after unprotect", {16'h0, wipers}, {16'h0, exp_w[1], exp_w[0]});
    chk("R12 sdo final", {31'h0, sdo === 1'bz}, 32'h1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule